// File: doc/BRIEF.md
# SCSI DMA REQ/ACK Handshake Sequencer

This block moves bytes between an external DMA controller and the asynchronous REQ/ACK handshake of a SCSI bus. The host register file writes one of three strobe addresses, which hold no data, to start a transfer. The block then runs the byte handshake in one of four roles: initiator send, initiator receive, target send or target receive. A DMA request (DRQ) is paced by the edges of the other party's REQ or ACK. The byte is latched in whichever direction the transfer runs. Minimum setup and recovery times are counted in clocks. A qualified end-of-process pulse stops the transfer and sets an end-of-DMA flag.

All bus and DMA control inputs are active high in this block. Pad polarity is handled outside it. Each control input passes through a multi-flop synchroniser before the sequencer uses it. One parameterised down-counter enforces the data-setup window before a strobe and the recovery gap before the next request. Clearing the DMA-mode input or seeing a bus reset drops the engine back to idle.

Top module: `scsi_dma_hs`

## Requirements
- R1: A one-cycle `reg_wr` with `dma_mode` high selects the transfer from the address. Address 5 starts a send: initiator send when `target_mode`=0, target send when `target_mode`=1. Address 6 starts target receive and address 7 starts initiator receive. A write to any other address, or any write with `dma_mode` low, leaves `dma_req`, `bus_req_out` and `bus_ack_out` low. The block never drives `bus_req_out` and `bus_ack_out` high together.
- R2: In initiator receive, a rising `bus_req_in` raises `dma_req` within 5 cycles and latches `bus_din` onto `host_rdata`. A rising `dma_ack` drops `dma_req`.
- R3: In initiator receive, `bus_ack_out` rises no earlier than 7 cycles (50 ns at 8 ns) after `bus_req_in` rises. The end of a `dma_rd` pulse drops `bus_ack_out` within 5 cycles. After that, `dma_req` for the next byte waits at least 7 cycles.
- R4: In initiator send, `dma_req` is high at start. The end of a `dma_wr` pulse places `host_wdata` on `bus_dout` with `bus_dout_en` high. `bus_ack_out` rises only while `bus_req_in` is high and no earlier than 5 cycles (40 ns) after the end of the write. `dma_req` rises in the same cycle as `bus_ack_out`, and `bus_ack_out` falls after `bus_req_in` falls.
- R5: In target send, the end of a `dma_wr` pulse drives the byte on `bus_dout`. `bus_req_out` rises no earlier than 5 cycles later and only while `bus_ack_in` is low. A high `bus_ack_in` drops `bus_req_out` and raises `dma_req`.
- R6: In target receive, `bus_req_out` rises at start. A high `bus_ack_in` latches `bus_din` onto `host_rdata`, drops `bus_req_out` and raises `dma_req`. The next `bus_req_out` waits for the end of a `dma_rd` pulse and comes at least 7 cycles after the later of `bus_ack_in` and `dma_rd` going low.
- R7: A `dma_eop` high for at least 4 synchronised cycles (30 ns) ends an active transfer. All handshake outputs go low and `end_dma` goes high. A shorter pulse is ignored. The next start clears `end_dma`.
- R8: Driving `dma_mode` low, or a high `bus_rst`, aborts to idle with `dma_req`, `bus_req_out` and `bus_ack_out` low, and does not set `end_dma`.
- R9: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe from the host register file |
| reg_addr | input | 3 | Register write address |
| dma_mode | input | 1 | DMA mode enable, synchronous level |
| target_mode | input | 1 | Role for a send: 1 target, 0 initiator |
| dma_ack | input | 1 | DMA acknowledge, asynchronous |
| dma_rd | input | 1 | DMA read strobe, asynchronous |
| dma_wr | input | 1 | DMA write strobe, asynchronous |
| dma_eop | input | 1 | End of process, asynchronous |
| host_wdata | input | 8 | Byte written by the DMA controller |
| host_rdata | output | 8 | Byte latched from the bus for the DMA controller |
| dma_req | output | 1 | DMA request |
| bus_rst | input | 1 | SCSI bus reset seen, asynchronous |
| bus_req_in | input | 1 | REQ observed on the bus |
| bus_ack_in | input | 1 | ACK observed on the bus |
| bus_req_out | output | 1 | REQ driven onto the bus (target roles) |
| bus_ack_out | output | 1 | ACK driven onto the bus (initiator roles) |
| bus_din | input | 8 | Data observed on the bus |
| bus_dout | output | 8 | Data to drive onto the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| end_dma | output | 1 | End-of-DMA flag |

## Verification
The bench builds the block with its defaults: an 8 ns period, 40 ns setup, 50 ns gap, 30 ns end-of-process width and two synchroniser stages. These give windows of 5, 7 and 4 cycles. The windows are short enough for the bench to measure both edges of each one. It checks the lower bound against a timestamp of its own and the upper bound against a timeout. These values also make a 2-cycle end-of-process pulse fall below the filter while a 6-cycle pulse clears it. Holding a bus strobe high across the setup window shows the wait for the opposite strobe.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int unsigned HS_ADDR_SEND  = 5;
    localparam int unsigned HS_ADDR_TRECV = 6;
    localparam int unsigned HS_ADDR_IRECV = 7;

    localparam int HS_NIN  = 7;
    localparam int IN_REQ  = 0;
    localparam int IN_ACK  = 1;
    localparam int IN_DACK = 2;
    localparam int IN_RD   = 3;
    localparam int IN_WR   = 4;
    localparam int IN_EOP  = 5;
    localparam int IN_RST  = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IS_WDMA, ST_IS_SETUP, ST_IS_ACK,
        ST_IR_WREQ, ST_IR_XFER,  ST_IR_REC,
        ST_TS_WDMA, ST_TS_SETUP, ST_TS_REQ,
        ST_TR_REQ,  ST_TR_DMA
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      drq;
        logic      req;
        logic      ack;
        logic      doe;
        logic      end_dma;
        logic      pend_req;
        logic      pend_rd;
        logic      pend_wr;
    } hs_ctrl_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES*W-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = d;
        end else begin : g_many
            assign chain_d = {chain_q[(STAGES-1)*W-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R3: an expired window stays expired until reloaded
    a_r3_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/hs_eop_filter.sv
module hs_eop_filter #(
    parameter int CNT_W   = 3,
    parameter int EOP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eop_s,
    output logic hit
);
    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        if (!eop_s)                          run_d = '0;
        else if (run_q == CNT_W'(EOP_CYC))   run_d = run_q;
        else                                 run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign hit = eop_s && (run_q == CNT_W'(EOP_CYC - 1));

    // R7: the qualified pulse fires once per long enough run
    a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import hs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 3,
    parameter int SETUP_CYC = 5,
    parameter int GAP_CYC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              dma_mode,
    input  logic              target_mode,
    input  logic              req_s,
    input  logic              ack_s,
    input  logic              dack_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic              rst_s,
    input  logic              eop_hit,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic              drq,
    output logic              req_o,
    output logic              ack_o,
    output logic              doe,
    output logic              end_dma,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);
    hs_ctrl_t          ctrl_d, ctrl_q;
    logic [DATA_W-1:0] dout_d, dout_q, rx_d, rx_q;
    logic [3:0]        prev_d, prev_q;   // {wr, rd, dack, req}

    logic req_rise, dack_rise, rd_end, wr_end;
    logic req_evt, rd_evt, wr_evt;
    logic is_send, is_trecv, is_irecv, start_hit, abort;

    always_comb begin
        req_rise  = req_s  & ~prev_q[0];
        dack_rise = dack_s & ~prev_q[1];
        rd_end    = ~rd_s  &  prev_q[2];
        wr_end    = ~wr_s  &  prev_q[3];
        req_evt   = ctrl_q.pend_req | req_rise;
        rd_evt    = ctrl_q.pend_rd  | rd_end;
        wr_evt    = ctrl_q.pend_wr  | wr_end;
        is_send   = (reg_addr == ADDR_W'(HS_ADDR_SEND));
        is_trecv  = (reg_addr == ADDR_W'(HS_ADDR_TRECV));
        is_irecv  = (reg_addr == ADDR_W'(HS_ADDR_IRECV));
        start_hit = reg_wr && dma_mode && (is_send || is_trecv || is_irecv);
        abort     = !dma_mode || rst_s;

        ctrl_d          = ctrl_q;
        ctrl_d.pend_req = req_evt;
        ctrl_d.pend_rd  = rd_evt;
        ctrl_d.pend_wr  = wr_evt;
        dout_d          = dout_q;
        rx_d            = rx_q;
        prev_d          = {wr_s, rd_s, dack_s, req_s};
        tmr_load        = 1'b0;
        tmr_val         = CNT_W'(GAP_CYC);

        if (dack_rise) ctrl_d.drq = 1'b0;

        unique case (ctrl_q.state)
            ST_IS_WDMA, ST_TS_WDMA: begin
                if (wr_evt) begin
                    ctrl_d.pend_wr = 1'b0;
                    ctrl_d.doe     = 1'b1;
                    dout_d         = host_wdata;
                    tmr_load       = 1'b1;
                    tmr_val        = CNT_W'(SETUP_CYC);
                    ctrl_d.state   = (ctrl_q.state == ST_IS_WDMA) ? ST_IS_SETUP : ST_TS_SETUP;
                end
            end
            ST_IS_SETUP: begin
                if (tmr_done && req_s) begin
                    ctrl_d.ack   = 1'b1;
                    ctrl_d.drq   = 1'b1;
                    ctrl_d.state = ST_IS_ACK;
                end
            end
            ST_IS_ACK: begin
                if (!req_s) begin
                    ctrl_d.ack   = 1'b0;
                    ctrl_d.state = ST_IS_WDMA;
                end
            end
            ST_IR_WREQ: begin
                if (req_evt) begin
                    ctrl_d.pend_req = 1'b0;
                    ctrl_d.drq      = 1'b1;
                    rx_d            = bus_din;
                    tmr_load        = 1'b1;
                    ctrl_d.state    = ST_IR_XFER;
                end
            end
            ST_IR_XFER: begin
                if (!ctrl_q.ack) begin
                    if (tmr_done) ctrl_d.ack = 1'b1;
                end else if (rd_evt) begin
                    ctrl_d.pend_rd = 1'b0;
                    ctrl_d.ack     = 1'b0;
                    tmr_load       = 1'b1;
                    ctrl_d.state   = ST_IR_REC;
                end
            end
            ST_IR_REC: begin
                if (tmr_done) ctrl_d.state = ST_IR_WREQ;
            end
            ST_TS_SETUP: begin
                if (tmr_done && !ack_s) begin
                    ctrl_d.req   = 1'b1;
                    ctrl_d.state = ST_TS_REQ;
                end
            end
            ST_TS_REQ: begin
                if (ack_s) begin
                    ctrl_d.req   = 1'b0;
                    ctrl_d.drq   = 1'b1;
                    ctrl_d.state = ST_TS_WDMA;
                end
            end
            ST_TR_REQ: begin
                if (ack_s) begin
                    rx_d           = bus_din;
                    ctrl_d.req     = 1'b0;
                    ctrl_d.drq     = 1'b1;
                    ctrl_d.pend_rd = 1'b0;
                    tmr_load       = 1'b1;
                    ctrl_d.state   = ST_TR_DMA;
                end
            end
            ST_TR_DMA: begin
                if (ack_s || rd_s) begin
                    tmr_load = 1'b1;
                end else if (rd_evt && tmr_done) begin
                    ctrl_d.pend_rd = 1'b0;
                    ctrl_d.req     = 1'b1;
                    ctrl_d.state   = ST_TR_REQ;
                end
            end
            default: ;
        endcase

        if (abort || (eop_hit && ctrl_q.state != ST_IDLE) || start_hit) begin
            ctrl_d.state    = ST_IDLE;
            ctrl_d.drq      = 1'b0;
            ctrl_d.req      = 1'b0;
            ctrl_d.ack      = 1'b0;
            ctrl_d.doe      = 1'b0;
            ctrl_d.pend_req = 1'b0;
            ctrl_d.pend_rd  = 1'b0;
            ctrl_d.pend_wr  = 1'b0;
            if (abort) begin
                // stays idle, flag untouched
            end else if (eop_hit && ctrl_q.state != ST_IDLE) begin
                ctrl_d.end_dma = 1'b1;
            end else begin
                ctrl_d.end_dma = 1'b0;
                if (is_send) begin
                    ctrl_d.drq   = 1'b1;
                    ctrl_d.state = target_mode ? ST_TS_WDMA : ST_IS_WDMA;
                end else if (is_trecv) begin
                    ctrl_d.req   = 1'b1;
                    ctrl_d.state = ST_TR_REQ;
                end else begin
                    ctrl_d.state = ST_IR_WREQ;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, default: 1'b0};
            dout_q <= '0;
            rx_q   <= '0;
            prev_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            dout_q <= dout_d;
            rx_q   <= rx_d;
            prev_q <= prev_d;
        end
    end

    assign drq     = ctrl_q.drq;
    assign req_o   = ctrl_q.req;
    assign ack_o   = ctrl_q.ack;
    assign doe     = ctrl_q.doe;
    assign end_dma = ctrl_q.end_dma;
    assign dout    = dout_q;
    assign rdata   = rx_q;

    // R9: nothing is driven while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) |-> (!ctrl_q.drq && !ctrl_q.req && !ctrl_q.ack && !ctrl_q.doe));
    // R1: one role drives one strobe only
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.req && ctrl_q.ack));
    // R5: outgoing byte does not change as REQ rises
    a_r5_req_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q.req) && ctrl_q.doe) |-> $stable(dout_q));
    // R4: outgoing byte does not change as ACK rises
    a_r4_ack_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q.ack) && ctrl_q.doe) |-> $stable(dout_q));
    // R4: in send the initiator answers only a live REQ
    a_r4_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q.ack) && ctrl_q.doe) |-> $past(req_s));
    // R8: dropping DMA mode leaves the engine idle
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> (ctrl_q.state == ST_IDLE));
    // R7: the end flag rises only from a qualified end pulse
    a_r7_end_from_eop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.end_dma) |-> $past(eop_hit));
endmodule

// File: rtl/scsi_dma_hs.sv
module scsi_dma_hs
    import hs_pkg::*;
#(
    parameter int CLK_NS      = 8,
    parameter int SETUP_NS    = 40,
    parameter int GAP_NS      = 50,
    parameter int EOP_NS      = 30,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              dma_mode,
    input  logic              target_mode,
    input  logic              dma_ack,
    input  logic              dma_rd,
    input  logic              dma_wr,
    input  logic              dma_eop,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dma_req,
    input  logic              bus_rst,
    input  logic              bus_req_in,
    input  logic              bus_ack_in,
    output logic              bus_req_out,
    output logic              bus_ack_out,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              end_dma
);
    localparam int SETUP_CYC = (SETUP_NS + CLK_NS - 1) / CLK_NS;
    localparam int GAP_CYC   = (GAP_NS   + CLK_NS - 1) / CLK_NS;
    localparam int EOP_CYC   = (EOP_NS   + CLK_NS - 1) / CLK_NS;
    localparam int MAX_A     = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int MAX_CYC   = (MAX_A > EOP_CYC) ? MAX_A : EOP_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic [HS_NIN-1:0] raw_in, sync_in;
    logic              eop_hit, tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_REQ]  = bus_req_in;
        raw_in[IN_ACK]  = bus_ack_in;
        raw_in[IN_DACK] = dma_ack;
        raw_in[IN_RD]   = dma_rd;
        raw_in[IN_WR]   = dma_wr;
        raw_in[IN_EOP]  = dma_eop;
        raw_in[IN_RST]  = bus_rst;
    end

    hs_sync #(.W(HS_NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
    );

    hs_eop_filter #(.CNT_W(CNT_W), .EOP_CYC(EOP_CYC)) u_eop (
        .clk(clk), .rst_n(rst_n), .eop_s(sync_in[IN_EOP]), .hit(eop_hit)
    );

    hs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
    );

    hs_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .dma_mode(dma_mode), .target_mode(target_mode),
        .req_s(sync_in[IN_REQ]), .ack_s(sync_in[IN_ACK]),
        .dack_s(sync_in[IN_DACK]), .rd_s(sync_in[IN_RD]),
        .wr_s(sync_in[IN_WR]), .rst_s(sync_in[IN_RST]),
        .eop_hit(eop_hit), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .host_wdata(host_wdata), .bus_din(bus_din),
        .drq(dma_req), .req_o(bus_req_out), .ack_o(bus_ack_out),
        .doe(bus_dout_en), .end_dma(end_dma),
        .dout(bus_dout), .rdata(host_rdata)
    );
endmodule

// File: tb/scsi_dma_hs_bench.sv
module scsi_dma_hs_bench;
    localparam int SETUP = 5;   // 40 ns at 8 ns
    localparam int GAP   = 7;   // 50 ns at 8 ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       dma_mode = 1'b0, target_mode = 1'b0;
    logic       dma_ack = 1'b0, dma_rd = 1'b0, dma_wr = 1'b0, dma_eop = 1'b0;
    logic [7:0] host_wdata = '0, bus_din = '0;
    logic       bus_rst = 1'b0, bus_req_in = 1'b0, bus_ack_in = 1'b0;
    logic [7:0] host_rdata, bus_dout;
    logic       dma_req, bus_req_out, bus_ack_out, bus_dout_en, end_dma;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scsi_dma_hs u_scsi_dma_hs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .dma_mode(dma_mode), .target_mode(target_mode),
        .dma_ack(dma_ack), .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_eop(dma_eop),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_req(dma_req),
        .bus_rst(bus_rst), .bus_req_in(bus_req_in), .bus_ack_in(bus_ack_in),
        .bus_req_out(bus_req_out), .bus_ack_out(bus_ack_out),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .end_dma(end_dma)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic check_rng(input string rq, input string what, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", rq, what, act, lo, hi);
        end
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0: return dma_req;
            1: return bus_req_out;
            2: return bus_ack_out;
            default: return end_dma;
        endcase
    endfunction

    // counts falling edges until the selected output equals val
    task automatic wait_sig(input int sel, input logic val, input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig(sel) !== val && n <= maxc);
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        dma_rd = 1'b1; idle(3); dma_rd = 1'b0;
    endtask

    task automatic dma_write_byte(input logic [7:0] b);
        dma_ack = 1'b1; host_wdata = b; idle(4);
        dma_wr = 1'b1; idle(3); dma_wr = 1'b0; dma_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R9", "dma_req after reset", dma_req, 0);
        check("R9", "req_out after reset", bus_req_out, 0);
        check("R9", "ack_out after reset", bus_ack_out, 0);
        check("R9", "dout_en/end after reset", {bus_dout_en, end_dma}, 0);
    endtask

    task automatic t_decode();
        dma_mode = 1'b0;
        reg_write(3'd5);
        idle(8);
        check("R1", "start with dma_mode low", {dma_req, bus_req_out, bus_ack_out}, 0);
        dma_mode = 1'b1;
        reg_write(3'd3);
        idle(8);
        check("R1", "write to non-strobe address", {dma_req, bus_req_out, bus_ack_out}, 0);
    endtask

    task automatic t_irecv();
        int n;
        reg_write(3'd7);
        idle(4);
        check("R1", "irecv start keeps dma_req low", dma_req, 0);
        bus_din = 8'hC3; bus_req_in = 1'b1;
        wait_sig(0, 1'b1, 10, n);
        check_rng("R2", "REQ to dma_req cycles", n, 1, 5);
        check("R2", "irecv latched byte", host_rdata, 8'hC3);
        wait_sig(2, 1'b1, 20, n);
        check_rng("R3", "REQ to ACK cycles", n + 3, GAP, GAP + 8);
        dma_ack = 1'b1;
        wait_sig(0, 1'b0, 8, n);
        check_rng("R2", "dack drops dma_req", n, 1, 5);
        bus_req_in = 1'b0;
        idle(2);
        pulse_rd();
        dma_ack = 1'b0;
        wait_sig(2, 1'b0, 8, n);
        check_rng("R3", "rd end drops ACK", n, 1, 5);
        bus_din = 8'h96; bus_req_in = 1'b1;
        wait_sig(0, 1'b1, 20, n);
        check_rng("R3", "ACK low to next dma_req", n, GAP, GAP + 7);
        check("R2", "irecv second byte", host_rdata, 8'h96);
        bus_req_in = 1'b0; dma_mode = 1'b0; idle(4); dma_mode = 1'b1;
    endtask

    task automatic t_isend();
        int n;
        target_mode = 1'b0;
        reg_write(3'd5);
        wait_sig(0, 1'b1, 5, n);
        check_rng("R4", "isend start dma_req", n, 0, 2);
        dma_ack = 1'b1;
        wait_sig(0, 1'b0, 8, n);
        host_wdata = 8'hA5; idle(2);
        dma_wr = 1'b1; idle(3); dma_wr = 1'b0; dma_ack = 1'b0;
        idle(14);
        check("R4", "no ACK without REQ", bus_ack_out, 0);
        check("R4", "isend byte on bus", {bus_dout_en, bus_dout}, {1'b1, 8'hA5});
        bus_req_in = 1'b1;
        wait_sig(2, 1'b1, 10, n);
        check_rng("R4", "REQ to ACK cycles", n, 1, 6);
        check("R4", "dma_req rises with ACK", dma_req, 1);
        bus_req_in = 1'b0;
        wait_sig(2, 1'b0, 8, n);
        check_rng("R4", "REQ low drops ACK", n, 1, 5);
        bus_req_in = 1'b1;
        dma_ack = 1'b1; host_wdata = 8'h5E; idle(3);
        dma_wr = 1'b1; idle(3); dma_wr = 1'b0; dma_ack = 1'b0;
        wait_sig(2, 1'b1, 20, n);
        check_rng("R4", "write end to ACK setup", n, SETUP, SETUP + 7);
        check("R4", "isend second byte", bus_dout, 8'h5E);
        bus_req_in = 1'b0; dma_mode = 1'b0; idle(4); dma_mode = 1'b1;
    endtask

    task automatic t_tsend();
        int n;
        target_mode = 1'b1;
        reg_write(3'd5);
        wait_sig(0, 1'b1, 5, n);
        dma_ack = 1'b1; host_wdata = 8'h3C; idle(3);
        dma_wr = 1'b1; idle(3); dma_wr = 1'b0; dma_ack = 1'b0;
        wait_sig(1, 1'b1, 20, n);
        check_rng("R5", "write end to REQ setup", n, SETUP, SETUP + 7);
        check("R5", "tsend byte on bus", {bus_dout_en, bus_dout}, {1'b1, 8'h3C});
        bus_ack_in = 1'b1;
        wait_sig(1, 1'b0, 8, n);
        check_rng("R5", "ACK drops REQ", n, 1, 5);
        check("R5", "ACK raises dma_req", dma_req, 1);
        dma_write_byte(8'h81);
        idle(15);
        check("R5", "REQ held off while ACK high", bus_req_out, 0);
        bus_ack_in = 1'b0;
        wait_sig(1, 1'b1, 10, n);
        check_rng("R5", "ACK low to REQ", n, 1, 6);
        check("R5", "tsend second byte", bus_dout, 8'h81);
        dma_mode = 1'b0; idle(4); dma_mode = 1'b1; target_mode = 1'b0;
    endtask

    task automatic t_trecv();
        int n;
        reg_write(3'd6);
        wait_sig(1, 1'b1, 4, n);
        check_rng("R6", "trecv start REQ", n, 0, 2);
        bus_din = 8'h5A; bus_ack_in = 1'b1;
        wait_sig(1, 1'b0, 8, n);
        check_rng("R6", "ACK drops REQ", n, 1, 5);
        check("R6", "trecv latched byte", host_rdata, 8'h5A);
        check("R6", "ACK raises dma_req", dma_req, 1);
        dma_ack = 1'b1; idle(3);
        pulse_rd();
        dma_ack = 1'b0; idle(3);
        check("R6", "no REQ while ACK high", bus_req_out, 0);
        bus_ack_in = 1'b0;
        wait_sig(1, 1'b1, 20, n);
        check_rng("R6", "ACK low to next REQ", n, GAP, GAP + 8);
        // still in target receive with REQ high: short end pulse
        dma_eop = 1'b1; idle(2); dma_eop = 1'b0;
        idle(8);
        check("R7", "short EOP ignored", {bus_req_out, end_dma}, {1'b1, 1'b0});
        dma_eop = 1'b1; idle(6); dma_eop = 1'b0;
        wait_sig(3, 1'b1, 8, n);
        check("R7", "long EOP sets end_dma", end_dma, 1);
        check("R7", "long EOP quiets outputs", {dma_req, bus_req_out, bus_ack_out}, 0);
        reg_write(3'd7);
        idle(2);
        check("R7", "new start clears end_dma", end_dma, 0);
        dma_mode = 1'b0; idle(4); dma_mode = 1'b1;
    endtask

    task automatic t_abort();
        int n;
        target_mode = 1'b0;
        reg_write(3'd5);
        wait_sig(0, 1'b1, 5, n);
        dma_mode = 1'b0;
        wait_sig(0, 1'b0, 4, n);
        check_rng("R8", "mode clear drops dma_req", n, 1, 2);
        check("R8", "abort leaves end_dma low", end_dma, 0);
        dma_mode = 1'b1;
        reg_write(3'd6);
        wait_sig(1, 1'b1, 4, n);
        bus_rst = 1'b1;
        wait_sig(1, 1'b0, 6, n);
        check_rng("R8", "bus reset drops REQ", n, 1, 4);
        bus_rst = 1'b0;
        idle(10);
        check("R8", "idle after bus reset", {bus_req_out, dma_req, end_dma}, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_decode();
        t_irecv();
        t_isend();
        t_tsend();
        t_trecv();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule